// File: doc/BRIEF.md
# Strobe/Wait Read Bus Servant

This block is a single-servant read channel that mixes strobe timing with a handshake fallback. A requester raises `req_o` together with an address. The servant fetches the word from an internal source whose latency is set per transfer. If the word is ready within a fixed access window of `T_ACCESS` cycles, the servant drives it onto the data bus without touching `wait_o`. The requester then samples at the end of the window, as a pure strobe protocol would.

When the latency is too long for the window, the servant raises `wait_o` early in the window. It holds `wait_o` until the word is on the bus and drops it in the same cycle that `data_en_o` rises. The requester stays on the bus past the strobe point and samples in the first cycle that `wait_o` is low. It then drops `req_o`, and the servant releases the bus. A new transfer cannot begin until the old request has been low for a cycle and `wait_o` is low.

Top module: `sw_bus_top`

## Requirements
- R1: After reset, `req_o`, `wait_o`, `data_en_o`, `done_o` and `busy_o` are low and `data_bus_o` is zero.
- R2: When `start_i` is accepted, `req_o` is high in the next cycle and `addr_bus_o` holds the accepted address, unchanged, for as long as `req_o` is high.
- R3: Counting the first cycle with `req_o` high as cycle 0, a latency L of at most `T_ACCESS`-1 keeps `wait_o` low for the whole transfer. Data is on the bus by cycle `T_ACCESS`, and the requester samples at the end of that cycle.
- R4: For L of at least `T_ACCESS`, `wait_o` is high in exactly cycles 1 to L. It falls in cycle L+1, which is the same cycle in which `data_en_o` rises, and it is never high together with `data_en_o`.
- R5: In the wait case, the requester samples at the end of cycle L+1. In all cases `done_o` is high in cycle max(`T_ACCESS`, L+1)+1, counted from the same origin.
- R6: The returned word is `{~addr, addr}`, with the address in the low half and its inverse in the high half. `data_bus_o` is zero whenever `data_en_o` is low.
- R7: `req_o` is low in the cycle after sampling (the `done_o` cycle). `data_en_o` is low from the cycle after that.
- R8: A `start_i` that arrives while `busy_o` is high is ignored. It changes neither the address nor the latency of the transfer in flight, and it starts no second transfer.
- R9: A `start_i` in the `done_o` cycle is accepted. `req_o` is then low for exactly that one cycle between the two transfers, and `wait_o` is low when the new request rises.
- R10: `done_o` is a one-cycle pulse, and `rdata_o` holds the sampled word from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a read |
| addr_i | input | ADDR_W | Address for the read |
| lat_i | input | LAT_W | Source latency in cycles for this read |
| busy_o | output | 1 | Requester is holding a request |
| done_o | output | 1 | Read complete, one-cycle pulse |
| rdata_o | output | 2*ADDR_W | Last sampled word |
| req_o | output | 1 | Bus request line |
| addr_bus_o | output | ADDR_W | Bus address |
| wait_o | output | 1 | Servant extension request |
| data_en_o | output | 1 | Servant drives the data bus |
| data_bus_o | output | 2*ADDR_W | Data bus, zero when released |

## Verification
The read is tried with latencies 0, 2 and 3, all of which fit the window. For these the bench confirms that `wait_o` stays low and that completion is pinned to the window edge whatever the latency. It is also tried with latencies 4, 7 and 15, where the completion time must track the latency and the number of `wait_o` cycles must equal it. The 3-to-4 pair sits on the window boundary and tells an off-by-one in the wait decision apart from a correct one. An intruding start mid-transfer and a start in the `done_o` cycle separate correct refusal from correct back-to-back acceptance.

// File: rtl/sw_pkg.sv
package sw_pkg;
  typedef enum logic [1:0] {M_IDLE, M_REQ, M_REST} mst_state_e;
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_DRIVE} srv_state_e;
endpackage

// File: rtl/sw_source.sv
module sw_source #(
  parameter int ADDR_W = 8,
  parameter int LAT_W  = 4,
  localparam int DATA_W = 2 * ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LAT_W-1:0]  lat_i,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [LAT_W-1:0]  lat_o,
  output logic              fire_o,
  output logic [DATA_W-1:0] data_o
);
  logic [LAT_W-1:0] lat_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
      cnt_q <= '0;
    end else begin
      if (load_i) lat_q <= lat_i;
      if (go_i) cnt_q <= lat_q;
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  // fire one cycle before the word must be on the bus
  assign fire_o = go_i ? (lat_q == '0) : (cnt_q == LAT_W'(1));
  assign lat_o  = lat_q;
  assign data_o = {~addr_i, addr_i};
endmodule

// File: rtl/sw_servant.sv
module sw_servant
  import sw_pkg::*;
#(
  parameter int T_ACCESS = 4,
  parameter int ADDR_W   = 8,
  parameter int LAT_W    = 4,
  localparam int DATA_W  = 2 * ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_load_i,
  input  logic [LAT_W-1:0]  cfg_lat_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wait_o,
  output logic              data_en_o,
  output logic [DATA_W-1:0] data_o
);
  srv_state_e        state_q;
  logic              wait_q, den_q, go, fire;
  logic [DATA_W-1:0] data_q, src_data;
  logic [LAT_W-1:0]  lat;

  assign go = req_i && (state_q == S_IDLE);

  sw_source #(.ADDR_W(ADDR_W), .LAT_W(LAT_W)) u_src (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cfg_load_i),
    .lat_i  (cfg_lat_i),
    .go_i   (go),
    .addr_i (addr_i),
    .lat_o  (lat),
    .fire_o (fire),
    .data_o (src_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      wait_q  <= 1'b0;
      den_q   <= 1'b0;
      data_q  <= '0;
    end else if (!req_i) begin
      state_q <= S_IDLE;
      wait_q  <= 1'b0;
      den_q   <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (fire) begin
            state_q <= S_DRIVE;
            den_q   <= 1'b1;
            data_q  <= src_data;
          end else begin
            state_q <= S_FETCH;
            wait_q  <= int'(lat) >= T_ACCESS;
          end
        end
        S_FETCH: begin
          if (fire) begin
            state_q <= S_DRIVE;
            den_q   <= 1'b1;
            wait_q  <= 1'b0;
            data_q  <= src_data;
          end
        end
        default: state_q <= S_DRIVE;
      endcase
    end
  end

  assign wait_o    = wait_q;
  assign data_en_o = den_q;
  assign data_o    = den_q ? data_q : '0;

  // R4
  wait_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_o |-> !data_en_o);
  // R4
  wait_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wait_o) |-> req_i && $past(req_i));
  // R7
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !data_en_o);
endmodule

// File: rtl/sw_requester.sv
module sw_requester
  import sw_pkg::*;
#(
  parameter int T_ACCESS = 4,
  parameter int ADDR_W   = 8,
  localparam int DATA_W  = 2 * ADDR_W,
  localparam int CW      = $clog2(T_ACCESS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wait_i,
  input  logic              data_en_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              accept_o,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  mst_state_e        state_q;
  logic [CW-1:0]     cnt_q;
  logic              done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] rdata_q;
  logic              strobe;

  assign accept_o = start_i && ((state_q == M_IDLE) || (state_q == M_REST && !wait_i));
  // strobe point reached; only an asserted wait extends the cycle
  assign strobe   = (state_q == M_REQ) && (cnt_q == CW'(T_ACCESS)) && !wait_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= M_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        state_q <= M_REQ;
        cnt_q   <= '0;
        addr_q  <= addr_i;
      end else begin
        case (state_q)
          M_REQ: begin
            if (strobe) begin
              state_q <= M_REST;
              done_q  <= 1'b1;
              rdata_q <= data_i;
            end else if (cnt_q != CW'(T_ACCESS)) begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          M_REST:  if (!wait_i) state_q <= M_IDLE;
          default: state_q <= M_IDLE;
        endcase
      end
    end
  end

  assign req_o   = (state_q == M_REQ);
  assign busy_o  = req_o;
  assign addr_o  = addr_q;
  assign done_o  = done_q;
  assign rdata_o = rdata_q;

  // R3
  strobe_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && cnt_q == CW'(T_ACCESS) && !wait_i) |-> data_en_i);
  // R9
  new_req_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> !wait_i);
  // R7
  req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !req_o);
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R2
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && $past(req_o)) |-> $stable(addr_o));
endmodule

// File: rtl/sw_bus_top.sv
module sw_bus_top #(
  parameter int T_ACCESS = 4,
  parameter int ADDR_W   = 8,
  parameter int LAT_W    = 4,
  localparam int DATA_W  = 2 * ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LAT_W-1:0]  lat_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_bus_o,
  output logic              wait_o,
  output logic              data_en_o,
  output logic [DATA_W-1:0] data_bus_o
);
  logic accept;

  sw_requester #(.T_ACCESS(T_ACCESS), .ADDR_W(ADDR_W)) u_mst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .addr_i    (addr_i),
    .wait_i    (wait_o),
    .data_en_i (data_en_o),
    .data_i    (data_bus_o),
    .accept_o  (accept),
    .req_o     (req_o),
    .addr_o    (addr_bus_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .rdata_o   (rdata_o)
  );

  sw_servant #(.T_ACCESS(T_ACCESS), .ADDR_W(ADDR_W), .LAT_W(LAT_W)) u_srv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_load_i (accept),
    .cfg_lat_i  (lat_i),
    .req_i      (req_o),
    .addr_i     (addr_bus_o),
    .wait_o     (wait_o),
    .data_en_o  (data_en_o),
    .data_o     (data_bus_o)
  );
endmodule

// File: tb/sw_bus_top_tb.sv
`timescale 1ns/1ps
module sw_bus_top_tb;
  localparam int T = 4;
  localparam int AW = 8;
  localparam int LW = 4;
  localparam int DW = 2 * AW;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [LW-1:0] lat = '0;
  logic busy, done, req, wt, den;
  logic [DW-1:0] rdata, dbus;
  logic [AW-1:0] abus;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  sw_bus_top #(.T_ACCESS(T), .ADDR_W(AW), .LAT_W(LW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .lat_i(lat),
    .busy_o(busy), .done_o(done), .rdata_o(rdata), .req_o(req),
    .addr_bus_o(abus), .wait_o(wt), .data_en_o(den), .data_bus_o(dbus));

  task automatic chk(input bit ok, input string req_tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req_tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    return {~a, a};
  endfunction

  // one transfer; optional intruding start at n==2; optional back-to-back start at done
  task automatic xfer(input logic [AW-1:0] a, input logic [LW-1:0] l,
                      input bit intrude, input bit chain, input logic [AW-1:0] a2);
    int n = 0, wcnt = 0, first_w = -1, exp_n, exp_w;
    bit addr_ok = 1'b1, excl_ok = 1'b1, req0;
    exp_n = ((T > l + 1) ? T : l + 1) + 1;
    exp_w = (l >= T) ? l : 0;
    @(negedge clk);
    start = 1'b1; addr = a; lat = l;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    req0 = req;
    chk(req0, "R2 req after accept", req0, 1);
    while (!done && n < 64) begin
      if (req && abus != a) addr_ok = 1'b0;
      if (wt) begin wcnt++; if (first_w < 0) first_w = n; end
      if (wt && den) excl_ok = 1'b0;
      if (intrude && n == 2) begin start = 1'b1; addr = ~a; lat = '0; end
      else if (intrude && n == 3) begin start = 1'b0; addr = a; lat = l; end
      @(posedge clk); n++;
      @(negedge clk);
    end
    chk(addr_ok, "R2 address held", abus, a);
    chk(n == exp_n, "R5 completion cycle", n, exp_n);
    chk(wcnt == exp_w, (l < T) ? "R3 wait unused" : "R4 wait cycles", wcnt, exp_w);
    if (l >= T) chk(first_w == 1, "R4 wait rise cycle", first_w, 1);
    chk(excl_ok, "R4 wait/data exclusive", 1, 0);
    chk(rdata == word_of(a), "R6 returned word", rdata, word_of(a));
    chk(!req, "R7 req low in done cycle", req, 0);
    if (chain) begin
      start = 1'b1; addr = a2; lat = '0;
      @(negedge clk);
      start = 1'b0;
      chk(req && !wt, "R9 back-to-back req after one low cycle", req, 1);
      chk(!done, "R10 done single pulse", done, 0);
      while (!done && n < 128) begin @(posedge clk); n++; @(negedge clk); end
      chk(rdata == word_of(a2), "R9 second word", rdata, word_of(a2));
    end else begin
      @(negedge clk);
      chk(!den && dbus == '0, "R7 bus released", dbus, 0);
      chk(!done && rdata == word_of(a), "R10 pulse and hold", done, 0);
      if (intrude) begin
        repeat (3) @(negedge clk);
        chk(!req && !busy, "R8 no second transfer", req, 0);
      end
    end
  endtask

  task automatic reset_test();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!req && !wt && !den && !done && !busy && dbus == '0, "R1 reset state",
        {req, wt, den, done, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic fast_tests();
    xfer(8'h3c, 4'd0, 1'b0, 1'b0, '0);
    xfer(8'ha5, 4'd2, 1'b0, 1'b0, '0);
    xfer(8'h01, 4'd3, 1'b0, 1'b0, '0);
  endtask

  task automatic slow_tests();
    xfer(8'h7e, 4'd4, 1'b0, 1'b0, '0);
    xfer(8'hc3, 4'd7, 1'b0, 1'b0, '0);
    xfer(8'hff, 4'd15, 1'b0, 1'b0, '0);
  endtask

  task automatic refuse_test();   // R8
    xfer(8'h5a, 4'd6, 1'b1, 1'b0, '0);
  endtask

  task automatic chain_test();    // R9
    xfer(8'h96, 4'd5, 1'b0, 1'b1, 8'h21);
    xfer(8'h00, 4'd1, 1'b0, 1'b1, 8'hee);
  endtask

  initial begin
    reset_test();
    fast_tests();
    slow_tests();
    refuse_test();
    chain_test();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule